// File: doc/BRIEF.md
# Seconds and Minutes Real-Time Clock with Periodic Interrupt

This peripheral keeps elapsed time in seconds and minutes from a 32.768 kHz time base, which reaches it as a one-cycle `tick` strobe in the system clock domain. A byte-wide register bus starts and stops the clock, reads the two counters, picks the interrupt period and services a sticky interrupt flag. A 15-bit prescaler divides the time base into half-second and one-second events. A start-up timer reports when the clock may be trusted. It counts 1024 ticks, about 31.25 ms, after the most recent start.

A control state machine has three states: `ST_OFF`, `ST_SETTLE` and `ST_STABLE`. Its transitions are:

- `ST_OFF` to `ST_SETTLE` on an arm write, which writes 1 to the run bit.
- `ST_SETTLE` to `ST_SETTLE` on a repeated arm write, which re-arms the timer.
- `ST_SETTLE` to `ST_STABLE` on the tick that completes the settle count.
- `ST_STABLE` to `ST_SETTLE` on an arm write.
- `ST_SETTLE` or `ST_STABLE` to `ST_OFF` on a disarm write, which writes 0 to the run bit.

Every arm write also clears the prescaler and both counters. The periodic interrupt is gated twice before it leaves the block, first by a local enable and then by the global enable input. The gated request drives both `irq` and `wake`, so it can bring the processor out of power-down.

Top module: `rtc_periph`

## Requirements
- R1: After reset every register reads 0x00, the block is stopped, and `irq` and `wake` are 0.
- R2: Writing address 0 with bit 7 = 1 sets the run bit and clears the seconds, minutes and prescaler, even when the clock is already running.
- R3: The stable flag (address 0 bit 6) reads 0 until STB_TICKS ticks have arrived since the last arm write, and 1 from that tick on. Any arm write or disarm write clears it.
- R4: While running, seconds (address 0 bits 5:0) advance once every 2^DIV_W ticks and roll from 59 to 0. That roll advances minutes (address 1 bits 5:0), which also roll from 59 to 0.
- R5: While the run bit is 0, ticks change neither counter.
- R6: The period select (address 1 bits 7:6) decodes as 00 for half-second, 01 for one-second, 10 for half-minute and 11 for one-minute. The selected event sets the interrupt flag (address 2 bit 1) on the tick that ends the period.
- R7: The flag stays set until a write to address 2 with bit 1 = 0. A write with bit 1 = 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R8: `irq` and `wake` are 1 exactly when the flag, the local enable (address 2 bit 0) and `glb_ie` are all 1.
- R9: Writes to the seconds and minutes fields are ignored. Address 1 stores only bits 7:6, address 2 stores only bit 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| glb_ie | input | 1 | Global interrupt enable from the processor |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| irq | output | 1 | Gated interrupt request |
| wake | output | 1 | Power-down wake request |

## Verification
Two of the block's functions can act on the same register in one cycle. The interrupt event sets the flag while software clears it, and the bench provokes this by driving a `tick` that ends a half-second and a clearing write to address 2 on the same falling edge. The check is that the flag reads back as set afterwards. Near-exhaustive sweeps with a small prescaler cover a full hour of seconds and minutes rolls. The bench also exercises every period select and every combination of the two enables, and the expected values come from tick arithmetic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STABLE = 2'd2
    } rtc_state_e;

    typedef enum logic [1:0] {
        SEL_HALF_SEC = 2'd0,
        SEL_SEC      = 2'd1,
        SEL_HALF_MIN = 2'd2,
        SEL_MIN      = 2'd3
    } rtc_sel_e;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_IRQ  = 2'd2;

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic half_ev,
    output logic sec_ev
);
    localparam int LOW_W = DIV_W - 1;

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart)
            div_q <= '0;
        else if (run && tick)
            div_q <= div_q + 1'b1;
    end

    // Event fires on the tick that toggles the top divider bit.
    assign half_ev = run && tick && !restart && (&div_q[LOW_W-1:0]);
    assign sec_ev  = half_ev && div_q[DIV_W-1];

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep #(
    parameter int CW    = 6,
    parameter int LIMIT = 59
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          sec_ev,
    output logic [CW-1:0] secs,
    output logic [CW-1:0] mins,
    output logic          half_min_ev,
    output logic          min_ev
);
    localparam logic [CW-1:0] TOP     = CW'(LIMIT);
    localparam logic [CW-1:0] MID_END = CW'((LIMIT + 1) / 2 - 1);

    logic sec_wrap;

    assign sec_wrap    = (secs == TOP);
    assign min_ev      = sec_ev && sec_wrap;
    assign half_min_ev = sec_ev && (sec_wrap || secs == MID_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secs <= '0;
            mins <= '0;
        end else if (restart) begin
            secs <= '0;
            mins <= '0;
        end else if (sec_ev) begin
            if (sec_wrap) begin
                secs <= '0;
                mins <= (mins == TOP) ? '0 : mins + 1'b1;
            end else begin
                secs <= secs + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
#(
    parameter int STB_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic tick,
    output logic run,
    output logic stable
);
    localparam int SW = $clog2(STB_TICKS + 1);
    localparam logic [SW-1:0] LAST = SW'(STB_TICKS - 1);

    rtc_state_e state_q, state_d;
    logic [SW-1:0] settle_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Settle counter: restarts on every arm write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            settle_q <= '0;
        else if (arm || state_q != ST_SETTLE)
            settle_q <= '0;
        else if (tick)
            settle_q <= settle_q + 1'b1;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (arm) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (disarm)                          state_d = ST_OFF;
                else if (arm)                        state_d = ST_SETTLE;
                else if (tick && settle_q == LAST)   state_d = ST_STABLE;
            end
            ST_STABLE: begin
                if (disarm)   state_d = ST_OFF;
                else if (arm) state_d = ST_SETTLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        run    = 1'b0;
        stable = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_SETTLE: run = 1'b1;
            ST_STABLE: begin
                run    = 1'b1;
                stable = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/rtc_periph.sv
module rtc_periph
    import rtc_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int STB_TICKS = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       glb_ie,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       wake
);
    localparam int CW = 6;

    logic          wr_stat, wr_ctrl, wr_irq;
    logic          arm, disarm;
    logic          run_en, stable;
    logic          half_ev, sec_ev, half_min_ev, min_ev;
    logic [CW-1:0] sec_q, min_q;
    rtc_sel_e      sel_q;
    logic          ie_q, flag_q, period_ev;

    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_irq  = bus_wr && (bus_addr == ADDR_IRQ);
    assign arm     = wr_stat && bus_wdata[7];
    assign disarm  = wr_stat && !bus_wdata[7];

    rtc_ctrl #(.STB_TICKS(STB_TICKS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .disarm (disarm),
        .tick   (tick),
        .run    (run_en),
        .stable (stable)
    );

    rtc_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_en),
        .restart (arm),
        .tick    (tick),
        .half_ev (half_ev),
        .sec_ev  (sec_ev)
    );

    rtc_timekeep #(.CW(CW), .LIMIT(59)) u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (arm),
        .sec_ev      (sec_ev),
        .secs        (sec_q),
        .mins        (min_q),
        .half_min_ev (half_min_ev),
        .min_ev      (min_ev)
    );

    always_comb begin
        unique case (sel_q)
            SEL_HALF_SEC: period_ev = half_ev;
            SEL_SEC:      period_ev = sec_ev;
            SEL_HALF_MIN: period_ev = half_min_ev;
            SEL_MIN:      period_ev = min_ev;
            default:      period_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_HALF_SEC;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) sel_q <= rtc_sel_e'(bus_wdata[7:6]);
            if (wr_irq)  ie_q  <= bus_wdata[0];
            // Event set takes priority over a software clear.
            if (period_ev)
                flag_q <= 1'b1;
            else if (wr_irq && !bus_wdata[1])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_STAT: bus_rdata = {run_en, stable, sec_q};
            ADDR_CTRL: bus_rdata = {sel_q, min_q};
            ADDR_IRQ:  bus_rdata = {6'b0, flag_q, ie_q};
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign irq  = flag_q && ie_q && glb_ie;
    assign wake = irq;

endmodule

// File: rtl/rtc_periph_chk.sv
module rtc_periph_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       glb_ie,
    input logic       irq,
    input logic       run_en,
    input logic       stable,
    input logic [5:0] secs,
    input logic [5:0] mins,
    input logic       flag
);
    a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[7])
        |=> (secs == 6'd0 && mins == 6'd0 && !stable && run_en));

    a_r3_stable_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        stable |-> run_en);

    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (secs <= 6'd59) && (mins <= 6'd59));

    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !(bus_wr && bus_addr == 2'd0))
        |=> ($stable(secs) && $stable(mins)));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_wr && bus_addr == 2'd2 && !bus_wdata[1])) |=> flag);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (glb_ie && flag));

endmodule

bind rtc_periph rtc_periph_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .glb_ie    (glb_ie),
    .irq       (irq),
    .run_en    (run_en),
    .stable    (stable),
    .secs      (sec_q),
    .mins      (min_q),
    .flag      (flag_q)
);

// File: tb/rtc_periph_test.sv
`timescale 1ns/1ps
module rtc_periph_test;
    localparam int DIV_W = 3;
    localparam int STB   = 16;
    localparam int SEC_T = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       glb_ie = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_periph #(.DIV_W(DIV_W), .STB_TICKS(STB)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .glb_ie(glb_ie),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int per[4];
        per[0] = SEC_T / 2; per[1] = SEC_T; per[2] = 30 * SEC_T; per[3] = 60 * SEC_T;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); check("R1 reset reg", v, 0);
        end
        check("R1 irq", int'(irq), 0);
        check("R1 wake", int'(wake), 0);

        // R3: settle timing
        wr(2'd0, 8'h80);
        rd(2'd0, v); check("R3 after arm", v, 8'h80);
        ticks(STB - 1);
        rd(2'd0, v); check("R3 before stable", v, 8'h80 | ((STB - 1) / SEC_T));
        ticks(1);
        rd(2'd0, v); check("R3 stable set", v, 8'hC0 | (STB / SEC_T));

        // R2: re-arm clears counters and stable
        wr(2'd0, 8'h80);
        rd(2'd0, v); check("R2 rearm clears", v, 8'h80);
        rd(2'd1, v); check("R2 minutes cleared", v, 0);

        // R4: sweep an hour plus, one second at a time
        for (int s = 1; s <= 3665; s++) begin
            ticks(SEC_T);
            rd(2'd0, v);
            check("R4 seconds", v, 8'h80 | ((s * SEC_T >= STB) ? 8'h40 : 0) | (s % 60));
            rd(2'd1, v);
            check("R4 minutes", v, (s / 60) % 60);
        end

        // R9: field write protection and unused address
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R9 minutes ignore write", v, 8'h01);
        wr(2'd1, 8'hC0);
        rd(2'd1, v); check("R9 select stored", v, 8'hC1);
        wr(2'd1, 8'h00);
        rd(2'd3, v); check("R9 addr3 zero", v, 0);
        wr(2'd2, 8'hFC);
        rd(2'd2, v); check("R9 irq reg bits", v, 0);

        // R5: hold while stopped
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R5 stop clears run and stable", v, 8'h05);
        ticks(3 * SEC_T);
        rd(2'd0, v); check("R5 seconds hold", v, 8'h05);
        rd(2'd1, v); check("R5 minutes hold", v, 8'h01);
        wr(2'd0, 8'h3F);
        rd(2'd0, v); check("R9 seconds ignore write", v, 8'h05);

        // R6 and R8: each period select
        glb_ie = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wr(2'd1, 8'(k << 6));
            wr(2'd0, 8'h80);
            wr(2'd2, 8'h01);
            ticks(per[k] - 1);
            rd(2'd2, v); check("R6 no flag before period", v, 8'h01);
            check("R8 irq low before period", int'(irq), 0);
            ticks(1);
            rd(2'd2, v); check("R6 flag at period", v, 8'h03);
            check("R8 irq high", int'(irq), 1);
            check("R8 wake high", int'(wake), 1);
        end

        // R7: sticky and write-1 no effect
        ticks(SEC_T);
        rd(2'd2, v); check("R7 flag stays", v, 8'h03);
        wr(2'd2, 8'h03);
        rd(2'd2, v); check("R7 write one keeps", v, 8'h03);
        wr(2'd2, 8'h01);
        rd(2'd2, v); check("R7 write zero clears", v, 8'h01);

        // R8: gating combinations with flag set
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h00);
        ticks(SEC_T / 2);
        for (int ie = 0; ie < 2; ie++) begin
            for (int g = 0; g < 2; g++) begin
                wr(2'd2, 8'(8'h02 | ie));
                glb_ie = g[0];
                #1;
                check("R8 irq gate", int'(irq), ie & g);
                check("R8 wake gate", int'(wake), ie & g);
            end
        end

        // R7: event and clearing write in the same cycle
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h01);
        ticks(SEC_T / 2 - 1);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(2'd2, v); check("R7 set wins over clear", v, 8'h03);
        wr(2'd2, 8'h01);
        rd(2'd2, v); check("R7 later clear works", v, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule